// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer of 9-bit words that sits between two clock domains. The writer pushes a word on a rising write-clock edge when both of its enables are high. The reader pops a word on a rising read-clock edge when both of its enables are high. The read word appears on a registered output that changes only when a read takes place. The two clocks may be one shared clock or two unrelated clocks. Each pointer crosses into the other domain as a Gray code through a two-stage synchroniser. Full is computed beside the write pointer and Empty beside the read pointer. The storage depth is 2**ADDR_W words. The default is 1024, and ADDR_W = 13 gives an 8192-word buffer.

Two programmable flags help the system react before the hard limits are reached. Almost-empty warns when few words remain stored. Almost-full warns when little free space remains. Both thresholds reset to 7. The load input takes over the write port to reprogram them. While load is high, each write cycle with both enables high stores one 9-bit half of a threshold instead of a FIFO word. A four-state sequencer picks which half, in the order LD_AE_LO → LD_AE_HI → LD_AF_LO → LD_AF_HI and then back to LD_AE_LO. Every transition is taken on a load-qualified write. Any cycle with load low sends the sequencer back to LD_AE_LO. An output enable turns the read data bus to high impedance.

Top module: `dual_clock_fifo_pf`

## Requirements
- R1: Words are read out in the order they were written, 9 bits wide, and the buffer holds exactly 2**ADDR_W words (1024 by default).
- R2: A word is stored only on a write-clock edge where wr_en_a and wr_en_b are both 1 and ofs_load is 0; one enable alone stores nothing.
- R3: rd_data takes the next stored word after a read-clock edge where rd_en_a and rd_en_b are both 1 and the FIFO is not empty; otherwise it holds its last value.
- R4: The FIFO works with independent clocks and with one shared clock. After a write into an empty FIFO, empty falls within 4 read-clock cycles.
- R5: full is 1 while 2**ADDR_W words are stored and empty is 1 while none are. A write while full and a read while empty are ignored and move no pointer.
- R6: almost_empty is 1 exactly when the stored count is at or below the almost-empty threshold, which is 7 after reset.
- R7: almost_full is 1 exactly when the free space is at or below the almost-full threshold, which is 7 after reset.
- R8: With ofs_load high, successive cycles with both write enables high write wr_data into almost-empty bits [8:0], then almost-empty bits [17:9], then almost-full bits [8:0], then almost-full bits [17:9], and then wrap to the first. A cycle with ofs_load low restarts the sequence at the first, and no FIFO word is stored during loading.
- R9: rd_data is high impedance while out_en is 0 and drives the registered read word while out_en is 1.
- R10: An active-low rst_n empties the FIFO, restores both thresholds to 7 and restarts the load sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| ofs_load | input | 1 | Routes write cycles to the threshold registers |
| wr_data | input | DATA_W | Write word or threshold half |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| out_en | input | 1 | Drives rd_data when 1, high impedance when 0 |
| rd_data | output | DATA_W | Registered read word |
| empty | output | 1 | No word stored (read domain) |
| full | output | 1 | All entries stored (write domain) |
| almost_empty | output | 1 | Count at or below the almost-empty threshold (read domain) |
| almost_full | output | 1 | Free space at or below the almost-full threshold (write domain) |

## Verification
Some properties are checked on every cycle. No pointer moves on a write while full, a read while empty or a load cycle. Each pointer advances by at most one step, and its Gray copy changes by a single bit. The read register holds steady without a read. An empty FIFO always shows almost-empty and a full one always shows almost-full. Other behaviour only the bench scenarios can show. This covers the word order across unrelated and shared clocks, the latency until empty falls, the exact threshold crossing points, and which bus half lands in which threshold field. It also covers sequence wrap and restart, high impedance under out_en, and the state after reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Threshold-load sequencer states, in load order
    typedef enum logic [1:0] {
        LD_AE_LO = 2'd0,
        LD_AE_HI = 2'd1,
        LD_AF_LO = 2'd2,
        LD_AF_HI = 2'd3
    } ofs_state_t;

    // Gray to binary for any width up to 32 (upper bits zero)
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Output register moves only on an accepted read
    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int DW     = 9,
    parameter int AW     = 10,
    parameter int AE_DEF = 7,
    parameter int AF_DEF = 7
) (
    input  logic            wclk,
    input  logic            rst_n,
    input  logic            wen_a,
    input  logic            wen_b,
    input  logic            ld,
    input  logic [DW-1:0]   din,
    input  logic [AW:0]     rgray_s,
    output logic [AW:0]     wbin,
    output logic [AW:0]     wgray,
    output logic            mem_we,
    output logic            full,
    output logic            af,
    output logic [2*DW-1:0] ae_ofs
);

    localparam int              PW      = AW + 1;
    localparam int              OW      = 2 * DW;
    localparam logic [PW-1:0]   DEPTH_P = PW'(1) << AW;
    localparam logic [OW-1:0]   AE_RST  = OW'(AE_DEF);
    localparam logic [OW-1:0]   AF_RST  = OW'(AF_DEF);

    ofs_state_t     st, st_nx;
    logic           both_en;
    logic [3:0]     wr_sel;
    logic [PW-1:0]  rbin_s, used, free_sp, wbin_nx;
    logic [OW-1:0]  af_ofs;

    assign both_en = wen_a & wen_b;

    // ---- pointer arithmetic ------------------------------------------
    assign rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
    assign used    = wbin - rbin_s;
    assign full    = used[AW];
    assign free_sp = DEPTH_P - used;
    assign af      = OW'(free_sp) <= af_ofs;
    assign mem_we  = both_en & ~ld & ~full;
    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // ---- threshold-load sequencer: state register ----------------------
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st <= LD_AE_LO;
        end else begin
            st <= st_nx;
        end
    end

    // ---- next state ----------------------------------------------------
    always_comb begin
        st_nx = st;
        if (!ld) begin
            st_nx = LD_AE_LO;
        end else if (both_en) begin
            unique case (st)
                LD_AE_LO: st_nx = LD_AE_HI;
                LD_AE_HI: st_nx = LD_AF_LO;
                LD_AF_LO: st_nx = LD_AF_HI;
                LD_AF_HI: st_nx = LD_AE_LO;
            endcase
        end
    end

    // ---- outputs: one-hot half select ------------------------------------
    always_comb begin
        wr_sel = '0;
        if (ld && both_en) begin
            unique case (st)
                LD_AE_LO: wr_sel[0] = 1'b1;
                LD_AE_HI: wr_sel[1] = 1'b1;
                LD_AF_LO: wr_sel[2] = 1'b1;
                LD_AF_HI: wr_sel[3] = 1'b1;
            endcase
        end
    end

    // ---- threshold halves ---------------------------------------------------
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [DW-1:0] ae_q, af_q;
        always_ff @(posedge wclk or negedge rst_n) begin
            if (!rst_n) begin
                ae_q <= AE_RST[h*DW +: DW];
                af_q <= AF_RST[h*DW +: DW];
            end else begin
                if (wr_sel[h])   ae_q <= din;
                if (wr_sel[2+h]) af_q <= din;
            end
        end
        assign ae_ofs[h*DW +: DW] = ae_q;
        assign af_ofs[h*DW +: DW] = af_q;
    end

endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic            rclk,
    input  logic            rst_n,
    input  logic            ren_a,
    input  logic            ren_b,
    input  logic [AW:0]     wgray_s,
    input  logic [2*DW-1:0] ae_ofs_s,
    output logic [AW:0]     rbin,
    output logic [AW:0]     rgray,
    output logic            rd_fire,
    output logic            empty,
    output logic            ae
);

    localparam int PW = AW + 1;
    localparam int OW = 2 * DW;

    logic [PW-1:0] wbin_s, cnt, rbin_nx;

    assign wbin_s  = PW'(gray_to_bin(32'(wgray_s)));
    assign cnt     = wbin_s - rbin;
    assign empty   = (cnt == '0);
    assign ae      = OW'(cnt) <= ae_ofs_s;
    assign rd_fire = ren_a & ren_b & ~empty;
    assign rbin_nx = rbin + PW'(1);

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_fire) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

endmodule

// File: rtl/dual_clock_fifo_pf.sv
module dual_clock_fifo_pf #(
    parameter int DATA_W     = 9,
    parameter int ADDR_W     = 10,
    parameter int AE_DEFAULT = 7,
    parameter int AF_DEFAULT = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic              ofs_load,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);

    localparam int PW = ADDR_W + 1;
    localparam int OW = 2 * DATA_W;

    logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic [OW-1:0]     ae_ofs, ae_ofs_s;
    logic              mem_we, rd_fire;
    logic [DATA_W-1:0] q_int;

    dcf_wr_side #(
        .DW(DATA_W), .AW(ADDR_W), .AE_DEF(AE_DEFAULT), .AF_DEF(AF_DEFAULT)
    ) u_wr (
        .wclk(wr_clk), .rst_n(rst_n), .wen_a(wr_en_a), .wen_b(wr_en_b),
        .ld(ofs_load), .din(wr_data), .rgray_s(rgray_s),
        .wbin(wbin), .wgray(wgray), .mem_we(mem_we), .full(full),
        .af(almost_full), .ae_ofs(ae_ofs)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(OW), .RST_VAL(OW'(AE_DEFAULT))) u_ofs (
        .clk(rd_clk), .rst_n(rst_n), .d(ae_ofs), .q(ae_ofs_s)
    );

    dcf_rd_side #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
        .rclk(rd_clk), .rst_n(rst_n), .ren_a(rd_en_a), .ren_b(rd_en_b),
        .wgray_s(wgray_s), .ae_ofs_s(ae_ofs_s),
        .rbin(rbin), .rgray(rgray), .rd_fire(rd_fire),
        .empty(empty), .ae(almost_empty)
    );

    dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(mem_we), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
        .rclk(rd_clk), .re(rd_fire), .raddr(rbin[ADDR_W-1:0]), .rdata(q_int)
    );

    assign rd_data = out_en ? q_int : {DATA_W{1'bz}};

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 10
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_en_a,
    input logic              wr_en_b,
    input logic              ofs_load,
    input logic              rd_en_a,
    input logic              rd_en_b,
    input logic              full,
    input logic              empty,
    input logic              almost_full,
    input logic              almost_empty,
    input logic [ADDR_W:0]   wbin,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   rbin,
    input logic [DATA_W-1:0] q_int
);

    p_no_overflow_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en_a && wr_en_b) |=> $stable(wbin));

    p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en_a && rd_en_b) |=> $stable(rbin));

    p_load_no_push_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ofs_load |=> $stable(wbin));

    p_single_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1));

    p_gray_step_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

    p_hold_q_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty || !(rd_en_a && rd_en_b)) |=> $stable(q_int));

    p_ae_on_empty_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    p_af_on_full_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);

endmodule

bind dual_clock_fifo_pf dcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dcf_checker (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .ofs_load(ofs_load),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .full(full), .empty(empty), .almost_full(almost_full), .almost_empty(almost_empty),
    .wbin(wbin), .wgray(wgray), .rbin(rbin), .q_int(q_int)
);

// File: tb/test_dual_clock_fifo_pf.sv
module test_dual_clock_fifo_pf;

    localparam int DW    = 9;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0, rclk_free = 1'b0, same_clk = 1'b0, rst_n = 1'b1;
    wire  rd_clk;
    logic wen_a = 1'b0, wen_b = 1'b0, ld = 1'b0, ren_a = 1'b0, ren_b = 1'b0, oe = 1'b1;
    logic [DW-1:0] din = '0;
    wire  [DW-1:0] rd_data;
    wire  empty, full, ae, af;

    int n_chk = 0, n_err = 0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] last_q = '0;
    bit   have_q = 1'b0;

    always #10 wr_clk    = ~wr_clk;      // 50 MHz
    always #13 rclk_free = ~rclk_free;
    assign rd_clk = same_clk ? wr_clk : rclk_free;

    dual_clock_fifo_pf i_dual_clock_fifo_pf (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en_a(wen_a), .wr_en_b(wen_b), .ofs_load(ld), .wr_data(din),
        .rd_en_a(ren_a), .rd_en_b(ren_b), .out_en(oe), .rd_data(rd_data),
        .empty(empty), .full(full), .almost_empty(ae), .almost_full(af)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic logic [DW-1:0] pat(input int k);
        return DW'(k * 7 + 3);
    endfunction

    task automatic settle();
        repeat (5) @(negedge rd_clk);
        repeat (5) @(negedge wr_clk);
    endtask

    task automatic do_reset();
        @(negedge wr_clk);
        rst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        exp_q.delete();
        rst_n = 1'b1;
        settle();
    endtask

    task automatic wr(input logic [DW-1:0] d, input bit a = 1, input bit b = 1);
        @(negedge wr_clk);
        wen_a = a; wen_b = b; din = d;
        if (a && b && !full) exp_q.push_back(d);
        @(negedge wr_clk);
        wen_a = 0; wen_b = 0;
    endtask

    task automatic fill(input int n, input int base);
        for (int k = 0; k < n; k++) wr(pat(base + k));
    endtask

    task automatic rd(input bit a, input bit b, input string req_go, input string req_hold);
        bit go;
        logic [DW-1:0] e;
        @(negedge rd_clk);
        ren_a = a; ren_b = b;
        go = a && b && !empty;
        e  = last_q;
        if (go) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else chk(1'b0, "R5 read from model-empty FIFO", 1, 0);
        end
        @(negedge rd_clk);
        ren_a = 0; ren_b = 0;
        if (go || have_q)
            chk(rd_data == e, go ? req_go : req_hold, int'(rd_data), int'(e));
        if (go) begin last_q = e; have_q = 1'b1; end
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() > 0 && guard < 4 * DEPTH) begin
            rd(1, 1, "R1 order", "R3 hold");
            guard++;
        end
        settle();
    endtask

    task automatic load_seq(input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                            input logic [DW-1:0] w2, input logic [DW-1:0] w3,
                            input bit extra, input logic [DW-1:0] w4);
        @(negedge wr_clk); ld = 1; wen_a = 1; wen_b = 1; din = w0;
        @(negedge wr_clk); din = w1;
        @(negedge wr_clk); din = w2;
        @(negedge wr_clk); din = w3;
        if (extra) begin @(negedge wr_clk); din = w4; end
        @(negedge wr_clk); ld = 0; wen_a = 0; wen_b = 0;
        settle();
    endtask

    task automatic rand_run(input int n);
        bit wdone = 1'b0;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    bit a, b;
                    logic [DW-1:0] d;
                    @(negedge wr_clk);
                    a = ($urandom % 4) != 0;
                    b = ($urandom % 4) != 0;
                    d = DW'($urandom);
                    wen_a = a; wen_b = b; din = d;
                    if (a && b && !full) exp_q.push_back(d);
                end
                @(negedge wr_clk);
                wen_a = 0; wen_b = 0;
                wdone = 1'b1;
            end
            begin
                bit pend = 1'b0;
                logic [DW-1:0] e = '0;
                forever begin
                    bit a, b;
                    @(negedge rd_clk);
                    if (pend) begin
                        chk(rd_data == e, "R4 random order", int'(rd_data), int'(e));
                        pend = 1'b0;
                    end
                    ren_a = 0; ren_b = 0;
                    if (wdone && exp_q.size() == 0) break;
                    a = ($urandom % 4) != 0;
                    b = ($urandom % 4) != 0;
                    ren_a = a; ren_b = b;
                    if (a && b && !empty) begin
                        if (exp_q.size() > 0) begin
                            e = exp_q.pop_front();
                            pend = 1'b1;
                        end else chk(1'b0, "R5 random read with model empty", 1, 0);
                    end
                end
            end
        join
        settle();
    endtask

    initial begin
        #3_500_000;
        n_err++;
        $display("FAIL R4 watchdog: actual=%0d expected=%0d", 0, 1);
        report();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        #1 rst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        rst_n = 1'b1;
        settle();

        // Reset state
        chk(empty == 1, "R10 empty after reset", empty, 1);
        chk(full  == 0, "R10 full after reset",  full, 0);
        chk(ae    == 1, "R6 almost_empty at count 0", ae, 1);
        chk(af    == 0, "R7 almost_full at count 0",  af, 0);

        // R2: single enable stores nothing
        wr(9'h111, 1, 0);
        wr(9'h122, 0, 1);
        settle();
        chk(empty == 1, "R2 single write enable ignored", empty, 1);

        // R4: empty-fall latency
        wr(9'h1A5);
        n = 0;
        while (empty && n < 8) begin @(negedge rd_clk); n++; end
        chk(n <= 4 && !empty, "R4 empty fall latency", n, 4);
        wr(9'h05A);
        wr(9'h100);
        settle();

        rd(1, 1, "R1 first word", "R3 hold");
        rd(1, 0, "R3 unexpected read", "R3 single read enable hold");
        rd(0, 1, "R3 unexpected read", "R3 single read enable hold");
        oe = 1'b0;
        #1;
        chk(rd_data !== 9'h1A5, "R9 output released when out_en low", int'(rd_data), 0);
        oe = 1'b1;
        #1;
        chk(rd_data == 9'h1A5, "R9 output driven when out_en high", int'(rd_data), 9'h1A5);
        drain();
        chk(empty == 1, "R5 empty after drain", empty, 1);

        // R5: read while empty ignored
        rd(1, 1, "R5 read while empty", "R5 read while empty holds");
        wr(9'h0AA);
        settle();
        rd(1, 1, "R5 pointer unchanged by empty read", "R3 hold");
        settle();

        // R6: default almost-empty threshold
        fill(7, 0);
        settle();
        chk(ae == 1, "R6 count 7 at default threshold", ae, 1);
        wr(pat(7));
        settle();
        chk(ae == 0, "R6 count 8 above default threshold", ae, 0);
        drain();

        // R7/R5: default almost-full and full
        fill(DEPTH - 8, 100);
        chk(af == 0, "R7 free 8 above default", af, 0);
        wr(pat(99));
        chk(af == 1, "R7 free 7 at default", af, 1);
        fill(6, 200);
        chk(full == 0, "R5 one free entry", full, 0);
        wr(9'h1F0);
        chk(full == 1, "R5 full at capacity", full, 1);
        wr(9'h1FF);
        settle();
        chk(full == 1, "R5 write while full ignored", full, 1);
        chk(int'(exp_q.size()) == DEPTH, "R1 capacity", exp_q.size(), DEPTH);
        drain();
        chk(empty == 1, "R5 empty after full drain", empty, 1);

        // R8: load thresholds AE=3, AF=5
        load_seq(9'd3, 9'd0, 9'd5, 9'd0, 1'b0, 9'd0);
        chk(empty == 1, "R8 load stores no FIFO word", empty, 1);
        fill(3, 300);
        settle();
        chk(ae == 1, "R8 almost-empty low half: count 3", ae, 1);
        wr(pat(303));
        settle();
        chk(ae == 0, "R8 almost-empty low half: count 4", ae, 0);
        drain();
        fill(DEPTH - 6, 400);
        chk(af == 0, "R8 almost-full low half: free 6", af, 0);
        wr(pat(399));
        chk(af == 1, "R8 almost-full low half: free 5", af, 1);
        drain();

        // R8: high half lands at bits [17:9] (threshold 512)
        load_seq(9'd0, 9'd1, 9'd7, 9'd0, 1'b0, 9'd0);
        fill(512, 500);
        settle();
        chk(ae == 1, "R8 almost-empty high half: count 512", ae, 1);
        wr(pat(499));
        settle();
        chk(ae == 0, "R8 almost-empty high half: count 513", ae, 0);
        drain();

        // R8: fifth load word wraps to almost-empty low half
        load_seq(9'd2, 9'd0, 9'd7, 9'd0, 1'b1, 9'd4);
        fill(4, 600);
        settle();
        chk(ae == 1, "R8 wrap: count 4", ae, 1);
        wr(pat(604));
        settle();
        chk(ae == 0, "R8 wrap: count 5", ae, 0);
        drain();

        // R8: ofs_load low restarts at almost-empty low half
        load_seq(9'd6, 9'd0, 9'd7, 9'd0, 1'b0, 9'd0);
        @(negedge wr_clk); ld = 1; wen_a = 1; wen_b = 1; din = 9'd1;
        @(negedge wr_clk); ld = 0; wen_a = 0; wen_b = 0;
        settle();
        fill(1, 700);
        settle();
        chk(ae == 1, "R8 restart: count 1", ae, 1);
        wr(pat(701));
        settle();
        chk(ae == 0, "R8 restart: count 2", ae, 0);

        // R10: reset empties and restores thresholds
        do_reset();
        chk(empty == 1, "R10 reset empties FIFO", empty, 1);
        fill(7, 800);
        settle();
        chk(ae == 1, "R10 default threshold restored: count 7", ae, 1);
        wr(pat(807));
        settle();
        chk(ae == 0, "R10 default threshold restored: count 8", ae, 0);
        drain();

        // R4: random traffic, independent clocks
        rand_run(1500);
        chk(empty == 1, "R4 empty after random run", empty, 1);

        // R4: random traffic, shared clock
        same_clk = 1'b1;
        do_reset();
        rand_run(1500);
        chk(empty == 1, "R4 empty after shared-clock run", empty, 1);

        report();
        $finish;
    end

endmodule